// File: doc/BRIEF.md
# Descriptor Ring Pointer Manager

This block keeps the producer and consumer positions of one descriptor ring whose depth is a power of two. Software does not write an absolute tail position. It writes the number of descriptors it has just prepared to an increment register, and the block moves the tail by that amount. The block accepts an increment only if it fits in the free space. An increment that does not fit is dropped and sets a sticky overflow flag.

The DMA engine sees whether a descriptor is waiting, the index of that descriptor, and a 2-bit generation tag. The engine requests an advance to consume the descriptor, and the request is acknowledged only while the ring holds work. The tag starts at 1 after reset and steps modulo 4 each time the head index wraps back to slot 0. The engine passes the control word of the descriptor it fetched through the block, and the block writes the current tag into bits 25:24 of that word. A consumer can then tell fresh entries from stale ones by tag alone. One slot is always kept empty, so equal indices always mean an empty ring.

Software reads the tail index, a status word and the head index back through a small register port. The head index serves as the completion head position.

Top module: `ring_ptr_mgr`

## Requirements
- R1: After reset, head and tail indices are 0, both generation tags are 1, the overflow flag is 0, the ring reads empty and the free count is RING_DEPTH-1.
- R2: A write to register address 0 with a count from 1 up to the current free count moves the tail by that count, modulo RING_DEPTH, one cycle later. Reading address 0 returns the tail index in bits 15:0 and zeros above. Writes to addresses 1 to 3 change nothing.
- R3: A write to address 0 with a count of 0, or with a count larger than the free count, leaves the tail unchanged and sets the overflow flag (status bit 17). Only reset clears that flag.
- R4: Status bits 15:0 report the free count, (head - (tail + 1)) mod RING_DEPTH.
- R5: Status bit 16 is 1 exactly when head equals tail, and fetch_valid is then 0.
- R6: An advance request is acknowledged only while the ring is non-empty. Each acknowledged request moves the head up by one, modulo RING_DEPTH. A request made while the ring is empty leaves the head unchanged.
- R7: The head tag (status bits 25:24) steps by 1 modulo 4 when the head wraps to 0. The tail tag (status bits 27:26) steps by 1 when an accepted increment carries the tail to or past RING_DEPTH.
- R8: desc_out equals desc_in with bits 25:24 replaced by the head tag, and fetch_tag shows the same tag. During an acknowledged advance, both show the tag from before the head moves.
- R9: Reading address 2 returns the head index in bits 15:0 and zeros in bits 31:16. Reading address 3 returns zero.
- R10: Once RING_DEPTH-1 descriptors are outstanding, the free count is 0 and every further increment is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Register write address (0 = tail increment) |
| reg_wr_data | input | 32 | Register write data (descriptor count) |
| reg_rd_addr | input | 2 | Register read address |
| reg_rd_data | output | 32 | Register read data, combinational |
| eng_adv | input | 1 | Engine request to consume the head descriptor |
| eng_ack | output | 1 | Advance accepted this cycle |
| fetch_valid | output | 1 | A descriptor is waiting at the head |
| fetch_idx | output | IDX_W | Head slot index |
| fetch_tag | output | 2 | Generation tag of the head slot |
| desc_in | input | 32 | Control word of the fetched descriptor |
| desc_out | output | 32 | Control word with the tag stamped into bits 25:24 |

## Verification
The bench builds the block with RING_DEPTH = 8. At that depth the tail wraps, the head wraps and the ring fills within a few dozen cycles. Several laps push both tags through all four values and back past 0. The small depth also makes the full-ring limit and the oversize-count rejection quick to reach. Each laps step is checked against a ring model kept in the bench.

// File: rtl/ring_ptr_pkg.sv
package ring_ptr_pkg;

    localparam int          GEN_W     = 2;
    localparam logic [1:0]  GEN_RESET = 2'd1;
    localparam int          TAG_LSB   = 24;
    localparam int          WORD_W    = 32;

    typedef enum logic [1:0] {
        SEL_TAIL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_HEAD = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [3:0]       spare_hi;
        logic [GEN_W-1:0] tail_gen;
        logic [GEN_W-1:0] head_gen;
        logic [5:0]       spare_mid;
        logic             overflow;
        logic             empty;
        logic [15:0]      free_cnt;
    } stat_word_t;

    function automatic logic [GEN_W-1:0] gen_step(input logic [GEN_W-1:0] g);
        return g + GEN_W'(1);
    endfunction

    function automatic logic [WORD_W-1:0] stamp_tag(input logic [WORD_W-1:0] w,
                                                    input logic [GEN_W-1:0]  g);
        logic [WORD_W-1:0] r;
        r = w;
        r[TAG_LSB +: GEN_W] = g;
        return r;
    endfunction

endpackage

// File: rtl/ring_tail_ctrl.sv
module ring_tail_ctrl
    import ring_ptr_pkg::*;
#(
    parameter int RING_DEPTH = 16,
    localparam int IDX_W = $clog2(RING_DEPTH)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                add_req,
    input  logic [WORD_W-1:0]   add_cnt,
    input  logic [IDX_W-1:0]    free_cnt,
    output logic [IDX_W-1:0]    tail_idx,
    output logic [GEN_W-1:0]    tail_gen,
    output logic                overflow
);

    logic           cnt_fits;
    logic           add_ok;
    logic [IDX_W:0] tail_sum;

    always_comb begin
        cnt_fits = (add_cnt != '0) && (add_cnt <= WORD_W'(free_cnt));
        add_ok   = add_req && cnt_fits;
        tail_sum = {1'b0, tail_idx} + {1'b0, add_cnt[IDX_W-1:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tail_idx <= '0;
            tail_gen <= GEN_RESET;
            overflow <= 1'b0;
        end else begin
            if (add_ok) begin
                tail_idx <= tail_sum[IDX_W-1:0];
                if (tail_sum[IDX_W]) begin
                    tail_gen <= gen_step(tail_gen);
                end
            end
            if (add_req && !cnt_fits) begin
                overflow <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ring_head_ctrl.sv
module ring_head_ctrl
    import ring_ptr_pkg::*;
#(
    parameter int RING_DEPTH = 16,
    localparam int IDX_W = $clog2(RING_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_req,
    input  logic              nonempty,
    output logic              adv_ack,
    output logic [IDX_W-1:0]  head_idx,
    output logic [GEN_W-1:0]  head_gen
);

    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(RING_DEPTH - 1);

    logic at_last;

    always_comb begin
        adv_ack = adv_req && nonempty;
        at_last = (head_idx == LAST_SLOT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_idx <= '0;
            head_gen <= GEN_RESET;
        end else if (adv_ack) begin
            head_idx <= head_idx + IDX_W'(1);
            if (at_last) begin
                head_gen <= gen_step(head_gen);
            end
        end
    end

endmodule

// File: rtl/ring_status_view.sv
module ring_status_view
    import ring_ptr_pkg::*;
#(
    parameter int RING_DEPTH = 16,
    localparam int IDX_W = $clog2(RING_DEPTH)
) (
    input  logic [IDX_W-1:0]  head_idx,
    input  logic [IDX_W-1:0]  tail_idx,
    input  logic [GEN_W-1:0]  head_gen,
    input  logic [GEN_W-1:0]  tail_gen,
    input  logic              overflow,
    input  logic [1:0]        rd_sel,
    input  logic [WORD_W-1:0] desc_in,
    output logic [IDX_W-1:0]  free_cnt,
    output logic              empty,
    output logic [WORD_W-1:0] rd_data,
    output logic [WORD_W-1:0] desc_out
);

    stat_word_t stat;

    always_comb begin
        free_cnt = head_idx - (tail_idx + IDX_W'(1));
        empty    = (head_idx == tail_idx);

        stat           = '0;
        stat.free_cnt  = 16'(free_cnt);
        stat.empty     = empty;
        stat.overflow  = overflow;
        stat.head_gen  = head_gen;
        stat.tail_gen  = tail_gen;

        unique case (reg_sel_e'(rd_sel))
            SEL_TAIL: rd_data = WORD_W'(tail_idx);
            SEL_STAT: rd_data = stat;
            SEL_HEAD: rd_data = WORD_W'(head_idx);
            default:  rd_data = '0;
        endcase

        desc_out = stamp_tag(desc_in, head_gen);
    end

endmodule

// File: rtl/ring_ptr_mgr.sv
module ring_ptr_mgr
    import ring_ptr_pkg::*;
#(
    parameter int RING_DEPTH = 16,
    localparam int IDX_W = $clog2(RING_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_wr_addr,
    input  logic [31:0]       reg_wr_data,
    input  logic [1:0]        reg_rd_addr,
    output logic [31:0]       reg_rd_data,
    input  logic              eng_adv,
    output logic              eng_ack,
    output logic              fetch_valid,
    output logic [IDX_W-1:0]  fetch_idx,
    output logic [1:0]        fetch_tag,
    input  logic [31:0]       desc_in,
    output logic [31:0]       desc_out
);

    logic [IDX_W-1:0] head_idx;
    logic [IDX_W-1:0] tail_idx;
    logic [GEN_W-1:0] head_gen;
    logic [GEN_W-1:0] tail_gen;
    logic [IDX_W-1:0] free_cnt;
    logic             empty;
    logic             overflow;
    logic             add_req;

    assign add_req = reg_wr_en && (reg_sel_e'(reg_wr_addr) == SEL_TAIL);

    ring_tail_ctrl #(.RING_DEPTH(RING_DEPTH)) u_tail (
        .clk      (clk),
        .rst      (rst),
        .add_req  (add_req),
        .add_cnt  (reg_wr_data),
        .free_cnt (free_cnt),
        .tail_idx (tail_idx),
        .tail_gen (tail_gen),
        .overflow (overflow)
    );

    ring_head_ctrl #(.RING_DEPTH(RING_DEPTH)) u_head (
        .clk      (clk),
        .rst      (rst),
        .adv_req  (eng_adv),
        .nonempty (!empty),
        .adv_ack  (eng_ack),
        .head_idx (head_idx),
        .head_gen (head_gen)
    );

    ring_status_view #(.RING_DEPTH(RING_DEPTH)) u_view (
        .head_idx (head_idx),
        .tail_idx (tail_idx),
        .head_gen (head_gen),
        .tail_gen (tail_gen),
        .overflow (overflow),
        .rd_sel   (reg_rd_addr),
        .desc_in  (desc_in),
        .free_cnt (free_cnt),
        .empty    (empty),
        .rd_data  (reg_rd_data),
        .desc_out (desc_out)
    );

    assign fetch_valid = !empty;
    assign fetch_idx   = head_idx;
    assign fetch_tag   = head_gen;

endmodule

// File: rtl/ring_ptr_mgr_chk.sv
module ring_ptr_mgr_chk #(
    parameter int RING_DEPTH = 16,
    localparam int IDX_W = $clog2(RING_DEPTH)
) (
    input logic             clk,
    input logic             rst,
    input logic             add_req,
    input logic [31:0]      reg_wr_data,
    input logic [IDX_W-1:0] free_cnt,
    input logic [IDX_W-1:0] head_idx,
    input logic [IDX_W-1:0] tail_idx,
    input logic [1:0]       head_gen,
    input logic             overflow,
    input logic             eng_ack,
    input logic             fetch_valid,
    input logic [31:0]      desc_out
);

    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(RING_DEPTH - 1);

    p_reject_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (add_req && (reg_wr_data == 32'd0 || reg_wr_data > 32'(free_cnt)))
        |=> (overflow && $stable(tail_idx)));

    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    p_empty_r5: assert property (@(posedge clk) disable iff (rst)
        (head_idx == tail_idx) |-> !fetch_valid);

    p_ack_nonempty_r6: assert property (@(posedge clk) disable iff (rst)
        eng_ack |-> fetch_valid);

    p_head_step_r6: assert property (@(posedge clk) disable iff (rst)
        eng_ack |=> (head_idx == IDX_W'($past(head_idx) + IDX_W'(1))));

    p_head_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !eng_ack |=> $stable(head_idx));

    p_head_gen_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (eng_ack && head_idx == LAST_SLOT) |=> (head_gen == 2'($past(head_gen) + 2'd1)));

    p_head_gen_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (eng_ack && head_idx != LAST_SLOT) |=> $stable(head_gen));

    p_stamp_r8: assert property (@(posedge clk) disable iff (rst)
        desc_out[25:24] == head_gen);

endmodule

bind ring_ptr_mgr ring_ptr_mgr_chk #(.RING_DEPTH(RING_DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .add_req     (add_req),
    .reg_wr_data (reg_wr_data),
    .free_cnt    (free_cnt),
    .head_idx    (head_idx),
    .tail_idx    (tail_idx),
    .head_gen    (head_gen),
    .overflow    (overflow),
    .eng_ack     (eng_ack),
    .fetch_valid (fetch_valid),
    .desc_out    (desc_out)
);

// File: tb/ring_ptr_mgr_bench.sv
module ring_ptr_mgr_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int IDX_W      = $clog2(DEPTH);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             reg_wr_en = 1'b0;
    logic [1:0]       reg_wr_addr = '0;
    logic [31:0]      reg_wr_data = '0;
    logic [1:0]       reg_rd_addr = '0;
    logic [31:0]      reg_rd_data;
    logic             eng_adv = 1'b0;
    logic             eng_ack;
    logic             fetch_valid;
    logic [IDX_W-1:0] fetch_idx;
    logic [1:0]       fetch_tag;
    logic [31:0]      desc_in = '0;
    logic [31:0]      desc_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    int m_head, m_tail, m_hgen, m_tgen, m_ovf;

    always #(CLK_PERIOD/2) clk = ~clk;

    ring_ptr_mgr #(.RING_DEPTH(DEPTH)) u_ring_ptr_mgr (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .eng_adv(eng_adv), .eng_ack(eng_ack),
        .fetch_valid(fetch_valid), .fetch_idx(fetch_idx), .fetch_tag(fetch_tag),
        .desc_in(desc_in), .desc_out(desc_out)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    function automatic int m_free();
        return (m_head - m_tail - 1) & (DEPTH - 1);
    endfunction

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_rd_addr = a;
        #1 v = reg_rd_data;
    endtask

    task automatic push(input int n);
        reg_write(2'd0, 32'(n));
        if (n != 0 && n <= m_free()) begin
            m_tail = m_tail + n;
            if (m_tail >= DEPTH) begin
                m_tail = m_tail - DEPTH;
                m_tgen = (m_tgen + 1) & 3;
            end
        end else begin
            m_ovf = 1;
        end
    endtask

    task automatic consume(input string req, input logic [31:0] pattern);
        logic exp_ack;
        exp_ack = (m_head != m_tail);
        @(negedge clk);
        eng_adv = 1'b1; desc_in = pattern;
        #1;
        check(req, "eng_ack", 32'(eng_ack), 32'(exp_ack));
        check("R8", "fetch_tag", 32'(fetch_tag), 32'(m_hgen));
        check("R8", "desc_out", desc_out,
              {pattern[31:26], 2'(m_hgen), pattern[23:0]});
        @(negedge clk);
        eng_adv = 1'b0;
        if (exp_ack) begin
            m_head = m_head + 1;
            if (m_head == DEPTH) begin
                m_head = 0;
                m_hgen = (m_hgen + 1) & 3;
            end
        end
    endtask

    task automatic check_all(input string req);
        logic [31:0] v;
        logic [31:0] exp_stat;
        exp_stat = {4'b0, 2'(m_tgen), 2'(m_hgen), 6'b0, 1'(m_ovf),
                    1'(m_head == m_tail), 16'(m_free())};
        reg_read(2'd0, v); check(req, "tail reg", v, 32'(m_tail));
        reg_read(2'd1, v); check(req, "status reg", v, exp_stat);
        reg_read(2'd2, v); check(req, "head reg", v, 32'(m_head));
        check(req, "fetch_valid", 32'(fetch_valid), 32'(m_head != m_tail));
        check(req, "fetch_idx", 32'(fetch_idx), 32'(m_head));
    endtask

    task automatic t_reset();
        m_head = 0; m_tail = 0; m_hgen = 1; m_tgen = 1; m_ovf = 0;
        check_all("R1");
    endtask

    task automatic t_push_basic();
        logic [31:0] v;
        push(3);
        check_all("R2 R4/R5");
        reg_write(2'd1, 32'd2);
        reg_write(2'd3, 32'd1);
        check_all("R2 ignored-addr");
        reg_read(2'd3, v);
        check("R9", "spare reg", v, 32'd0);
    endtask

    task automatic t_consume();
        consume("R6", 32'hFFFF_FFFF);
        consume("R6", 32'h0000_0000);
        consume("R6", 32'hA5C3_5A3C);
        check_all("R5 R6");
        consume("R6 empty", 32'h1234_5678);
        check_all("R6 empty-hold");
    endtask

    task automatic t_reject();
        push(0);
        check_all("R3 zero");
        push(DEPTH);
        check_all("R3 oversize");
    endtask

    task automatic t_full();
        push(DEPTH - 1);
        check_all("R10 R7 tail wrap");
        push(1);
        check_all("R10 reject");
    endtask

    task automatic t_wrap();
        for (int i = 0; i < DEPTH - 1; i++) consume("R7", 32'(i * 32'h0101_0101));
        check_all("R7 R9 head wrap");
    endtask

    task automatic t_laps();
        for (int lap = 0; lap < 5; lap++) begin
            push(6);
            for (int i = 0; i < 6; i++) consume("R7 lap", 32'h0F0F_F0F0 ^ 32'(lap));
            check_all("R7 lap");
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_push_basic();
        t_consume();
        t_reject();
        t_full();
        t_wrap();
        t_laps();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule